// File: doc/BRIEF.md
# Set/Clear GPIO Port with Implicit Direction

This block is a 32-pin general-purpose I/O port on a simple memory-mapped register bus. Software never writes the output latch as a whole word. Instead, a "drive high" register sets the latch bit of every pin written with a 1, and a "drive low" register clears it. Either write also turns the selected pins into outputs. A third register releases pins back to input (high-impedance) mode, again only for bits written as 1.

Input sampling starts out blocked. The sampled pin levels stay zero until software has written the arming register once, with any data value. From then on, each pin level passes through a two-stage synchronizer. The result can be read back from the arming register's address and also drives one active-high interrupt request line per pin.

Top module: `gpio_sc_port`

## Requirements
- R1: After a synchronous active-low reset, every pin is an input (`pin_oe` = 0), the output latch is zero (`pin_out` = 0), sampling is unarmed, and reads at 0x100, 0x108 and 0x110 return 0.
- R2: A write to offset 0x108 sets the latch bit of every pin whose data bit is 1, effective on the next clock edge. A read of 0x108 returns the latch, and `pin_out` always shows the latch.
- R3: A write to offset 0x10C clears the latch bit of every pin whose data bit is 1.
- R4: Each pin written with a 1 at 0x108 or 0x10C becomes an output, so its `pin_oe` bit becomes 1.
- R5: A write to offset 0x100 turns every pin whose data bit is 1 into an input (`pin_oe` bit 0) and leaves its latch bit as it was. A read of 0x100 returns `pin_oe`, where 1 means the pin is driven.
- R6: Bits written as 0 at 0x100, 0x108 or 0x10C leave both the latch and the direction of those pins unchanged.
- R7: Until sampling is armed, a read of 0x110 returns 0 and `irq_req` is 0, whatever the pin inputs are.
- R8: Any write to 0x110 arms sampling permanently, whatever the data value. Once armed, a read of 0x110 returns `pin_in` delayed by exactly two clock edges, and the first valid sample appears two edges after the arming write.
- R9: Once sampling is armed, `irq_req[i]` equals the synchronized level of pin i, which is the same value that a read of 0x110 returns.
- R10: A write to any other offset changes nothing. A read of any other offset (0x10C included) returns 0, and so does the read bus when there is no read access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output latch |
| pin_oe | output | 32 | Per-pin drive enable, 1 = output |
| irq_req | output | 32 | Per-pin active-high interrupt request |

## Verification
On every cycle, the assertions check the following:
- each set, clear or release write moves exactly the selected latch and direction bits and no others;
- when there is no write, the latch and the direction stay as they are;
- the arming flag never drops;
- while sampling is unarmed, the interrupt lines stay low;
- once armed, the interrupt lines follow the pin inputs from two edges earlier.

Only the bench's scenarios can show two things. The first is that the value written to the arming register does not matter. The second is that read-back at each offset returns the right state after long mixed sequences of random writes. The bench also pins down the exact latency of the first valid sample after arming and shows that writes to unmapped offsets leave everything unchanged.

// File: rtl/gpio_sc_pkg.sv
// Package: offsets, write strobes and read selection shared by the port.
// Assumes a 12-bit byte-offset bus where each access lasts one cycle.
package gpio_sc_pkg;
    localparam int unsigned ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_RELEASE = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_HIGH    = 12'h108;
    localparam logic [ADDR_W-1:0] OFS_LOW     = 12'h10C;
    localparam logic [ADDR_W-1:0] OFS_SAMPLE  = 12'h110;

    typedef struct packed {
        logic release_w;
        logic high_w;
        logic low_w;
        logic arm_w;
    } wr_strobe_t;

    typedef enum logic [1:0] {
        RD_NONE,
        RD_DIR,
        RD_LATCH,
        RD_SAMPLE
    } rd_sel_t;
endpackage

// File: rtl/gpio_sc_decode.sv
// Module: turns one bus access into write strobes and a read selector.
// Assumes bus_sel marks a single-cycle access. Unmapped offsets decode to nothing.
module gpio_sc_decode
    import gpio_sc_pkg::*;
(
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output wr_strobe_t        strb,
    output rd_sel_t           rd_sel
);
    // Write decode: one strobe per mapped offset.
    always_comb begin
        strb = '0;
        if (bus_sel && bus_we) begin
            strb.release_w = (bus_addr == OFS_RELEASE);
            strb.high_w    = (bus_addr == OFS_HIGH);
            strb.low_w     = (bus_addr == OFS_LOW);
            strb.arm_w     = (bus_addr == OFS_SAMPLE);
        end
    end

    // Read decode: 0x10C and unmapped offsets read as nothing.
    always_comb begin
        rd_sel = RD_NONE;
        if (bus_sel && !bus_we) begin
            unique case (bus_addr)
                OFS_RELEASE: rd_sel = RD_DIR;
                OFS_HIGH:    rd_sel = RD_LATCH;
                OFS_SAMPLE:  rd_sel = RD_SAMPLE;
                default:     rd_sel = RD_NONE;
            endcase
        end
    end
endmodule

// File: rtl/gpio_sc_state.sv
// Module: holds the output latch, the per-pin drive enables and the arming flag.
// Assumes that at most one strobe is active per cycle (one access per cycle).
module gpio_sc_state
    import gpio_sc_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_strobe_t       strb,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] latch_q,
    output logic [NPINS-1:0] drive_q,
    output logic             armed_q
);
    // Latch update: a set or clear applies only to the bits written as 1.
    always_ff @(posedge clk) begin
        if (!rst_n)            latch_q <= '0;
        else if (strb.high_w)  latch_q <= latch_q | wdata;
        else if (strb.low_w)   latch_q <= latch_q & ~wdata;
    end

    // Direction: set/clear writes enable the driver, release writes disable it.
    always_ff @(posedge clk) begin
        if (!rst_n)                          drive_q <= '0;
        else if (strb.high_w || strb.low_w)  drive_q <= drive_q | wdata;
        else if (strb.release_w)             drive_q <= drive_q & ~wdata;
    end

    // Arming flag: the first write at the sample offset sets it; nothing clears it but reset.
    always_ff @(posedge clk) begin
        if (!rst_n)           armed_q <= 1'b0;
        else if (strb.arm_w)  armed_q <= 1'b1;
    end

    p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strb.high_w |=> ((latch_q & $past(wdata)) == $past(wdata)));
    p_clear_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        strb.low_w |=> ((latch_q & $past(wdata)) == '0));
    p_drive_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.high_w || strb.low_w) |=> ((drive_q & $past(wdata)) == $past(wdata)));
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strb.release_w |=> ((drive_q & $past(wdata)) == '0) && $stable(latch_q));
    p_untouched_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.high_w || strb.low_w || strb.release_w) |=>
            (((latch_q ^ $past(latch_q)) & ~$past(wdata)) == '0) &&
            (((drive_q ^ $past(drive_q)) & ~$past(wdata)) == '0));
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(strb.high_w || strb.low_w || strb.release_w) |=> $stable(latch_q) && $stable(drive_q));
    p_arm_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |=> armed_q);
endmodule

// File: rtl/gpio_sc_sync.sv
// Module: multi-stage synchronizer for the pin inputs, held at zero until armed.
// Assumes pin_in is asynchronous. The stage count comes from a parameter, two by default.
module gpio_sc_sync #(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] sampled
);
    logic [NPINS-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [NPINS-1:0] src;
        if (s == 0) begin : g_first
            assign src = pin_in;
        end else begin : g_next
            assign src = stg[s-1];
        end
        // Stage flop: cleared while unarmed, so no stale level leaks out.
        always_ff @(posedge clk) begin
            if (!rst_n || !armed) stg[s] <= '0;
            else                  stg[s] <= src;
        end
    end

    assign sampled = stg[STAGES-1];
endmodule

// File: rtl/gpio_sc_port.sv
// Module: top of the set/clear GPIO port with implicit direction and armed sampling.
// Assumes single-cycle bus accesses and a combinational read path from the address.
module gpio_sc_port
    import gpio_sc_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  irq_req
);
    wr_strobe_t       strb;
    rd_sel_t          rd_sel;
    logic [NPINS-1:0] latch_q;
    logic [NPINS-1:0] drive_q;
    logic [NPINS-1:0] sampled;
    logic             armed_q;

    gpio_sc_decode i_decode (
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .strb     (strb),
        .rd_sel   (rd_sel)
    );

    gpio_sc_state #(.NPINS(NPINS)) i_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .strb    (strb),
        .wdata   (bus_wdata),
        .latch_q (latch_q),
        .drive_q (drive_q),
        .armed_q (armed_q)
    );

    gpio_sc_sync #(.NPINS(NPINS), .STAGES(2)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (armed_q),
        .pin_in  (pin_in),
        .sampled (sampled)
    );

    // Read mux: picks the register the decoder selected, otherwise zero.
    always_comb begin
        unique case (rd_sel)
            RD_DIR:    bus_rdata = drive_q;
            RD_LATCH:  bus_rdata = latch_q;
            RD_SAMPLE: bus_rdata = sampled;
            default:   bus_rdata = '0;
        endcase
    end

    assign pin_out = latch_q;
    assign pin_oe  = drive_q;
    assign irq_req = sampled;

    p_quiet_unarmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> (irq_req == '0));
    p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(armed_q) && $past(armed_q, 2)) |-> (irq_req == $past(pin_in, 2)));
endmodule

// File: tb/test_gpio_sc_port.sv
module test_gpio_sc_port;
    localparam int N = 32;
    localparam logic [11:0] A_REL = 12'h100, A_HI = 12'h108, A_LO = 12'h10C, A_SMP = 12'h110;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_we = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata, pin_out, pin_oe, irq_req;
    logic [N-1:0]  pin_in = '0;

    int errors = 0, checks = 0;
    logic [N-1:0] m_lat = '0, m_oe = '0;

    always #4 clk = ~clk;

    gpio_sc_port i_gpio_sc_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_req(irq_req)
    );

    function automatic logic [N-1:0] f_lat(input logic [11:0] a, input logic [N-1:0] d,
                                           input logic [N-1:0] l);
        if (a == A_HI) return l | d;
        if (a == A_LO) return l & ~d;
        return l;
    endfunction

    function automatic logic [N-1:0] f_oe(input logic [11:0] a, input logic [N-1:0] d,
                                          input logic [N-1:0] o);
        if (a == A_HI || a == A_LO) return o | d;
        if (a == A_REL) return o & ~d;
        return o;
    endfunction

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        m_lat = f_lat(a, d, m_lat);
        m_oe  = f_oe(a, d, m_oe);
    endtask

    task automatic rd(input logic [11:0] a, output logic [N-1:0] v);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic chk_regs(input string req);
        logic [N-1:0] v;
        rd(A_HI, v);  chk({req, " latch read"}, v, m_lat);
        rd(A_REL, v); chk({req, " dir read"}, v, m_oe);
        chk({req, " pin_out"}, pin_out, m_lat);
        chk({req, " pin_oe"}, pin_oe, m_oe);
    endtask

    initial begin
        #(8 * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [N-1:0] v;
        void'($urandom(32'd2024));
        pin_in = '1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_regs("R1");
        rd(A_SMP, v); chk("R1 sample read", v, '0);
        chk("R1 irq", irq_req, '0);

        // R7: sampling blocked before arming
        pin_in = 32'hA5A5_3C3C;
        repeat (4) @(negedge clk);
        rd(A_SMP, v); chk("R7 sample unarmed", v, '0);
        chk("R7 irq unarmed", irq_req, '0);

        // R10: unmapped writes and reads
        wr(12'h104, '1); wr(12'h000, '1); wr(12'h10C + 12'h4 + 12'h8, '1);
        chk_regs("R10");
        rd(12'h104, v); chk("R10 unmapped read", v, '0);
        rd(A_LO, v);    chk("R10 clear-offset read", v, '0);
        rd(A_SMP, v);   chk("R10 no arm from unmapped", v, '0);
        chk("R10 idle rdata", bus_rdata, '0);

        // R8: arming with zero data, exact latency
        wr(A_SMP, '0);
        rd(A_SMP, v); chk("R8 zero right after arm", v, '0);
        @(negedge clk);
        rd(A_SMP, v); chk("R8 zero one edge later", v, '0);
        @(negedge clk);
        rd(A_SMP, v); chk("R8 valid two edges after arm", v, 32'hA5A5_3C3C);
        chk("R9 irq after arm", irq_req, 32'hA5A5_3C3C);

        // R8/R9: two-edge delay on a pin change
        pin_in = 32'h0F0F_1234;
        @(negedge clk);
        rd(A_SMP, v); chk("R8 old value one edge later", v, 32'hA5A5_3C3C);
        @(negedge clk);
        rd(A_SMP, v); chk("R8 new value two edges later", v, 32'h0F0F_1234);
        chk("R9 irq follows", irq_req, 32'h0F0F_1234);
        wr(A_SMP, '1);
        @(negedge clk);
        rd(A_SMP, v); chk("R8 stays armed", v, 32'h0F0F_1234);

        // R2..R6 directed corners
        wr(A_HI, '1);           chk_regs("R2 set all");
        wr(A_REL, 32'hFFFF_0000); chk_regs("R5 release keeps latch");
        wr(A_LO, 32'h0000_00FF); chk_regs("R3 clear low byte");
        wr(A_HI, '0);           chk_regs("R6 set zero data");
        wr(A_LO, '0);           chk_regs("R6 clear zero data");
        wr(A_REL, '0);          chk_regs("R6 release zero data");
        wr(A_LO, 32'h8000_0000); chk_regs("R4 clear drives pin");

        // Random mix
        for (int i = 0; i < 300; i++) begin
            logic [11:0] a;
            logic [N-1:0] d;
            int op;
            op = $urandom_range(0, 4);
            d  = $urandom();
            case (op)
                0: a = A_HI;
                1: a = A_LO;
                2: a = A_REL;
                3: a = A_SMP;
                default: a = 12'h0F0 + 12'($urandom_range(0, 3) * 4);
            endcase
            wr(a, d);
            chk_regs("R2/R3/R4/R5/R6 random");
            if ((i % 10) == 0) begin
                logic [N-1:0] p;
                p = $urandom();
                pin_in = p;
                repeat (2) @(negedge clk);
                rd(A_SMP, v); chk("R8 random sample", v, p);
                chk("R9 random irq", irq_req, p);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule